// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes an operation code, the accumulator value, a second operand and the current status byte. From these it works out a new accumulator value and a new status byte.

When the write enable is high, both results are captured in output registers on the rising clock edge. When it is low, the registers keep their contents. Register selection, operand fetch and instruction decode happen elsewhere. The caller feeds the registered status byte back to `flags_i` when it needs to chain operations such as multi-byte adds.

The status byte holds five flags at fixed positions, because branch and carry logic elsewhere decode them by bit:

| Bit | Flag |
|-----|------|
| 7 | sign |
| 6 | zero |
| 4 | half carry (between the low and high nibble) |
| 2 | even parity |
| 0 | carry / borrow |

The other three bits always read as 0.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears `acc_o` and `flags_o` to 0. With `wr_en_i` low, both outputs hold their previous values across the clock edge.
- R2: Status byte layout:
  - bit 7 is sign, bit 6 is zero, bit 4 is half carry, bit 2 is parity and bit 0 is carry.
  - Bits 5, 3 and 1 of `flags_o` are always 0, whatever the value of `flags_i`.
- R3: Add (code 0) and add with carry (code 1) produce `acc + opnd (+ flags_i[0] for code 1)`, keeping the low 8 bits.
  - Carry is set on a carry out of bit 7.
  - Half carry is set on a carry out of bit 3 into bit 4.
- R4: Subtract (code 2) and subtract with borrow (code 3) produce `acc - opnd (- flags_i[0] for code 3)`, keeping the low 8 bits.
  - Carry is set when the true difference is negative.
  - Half carry is set when the low nibble borrows.
- R5: For codes 0 to 7, the flags are computed from the 8-bit result:
  - sign is bit 7 of the result;
  - zero is set exactly when the result is 0;
  - parity is set exactly when the result has an even number of 1 bits.
- R6: Compare (code 7) sets all flags exactly as code 2 would, and writes the unchanged `acc_i` to `acc_o`.
- R7: AND (code 4), OR (code 5) and XOR (code 6) write the bitwise result and clear both carry and half carry.
- R8: Complement (code 8) writes the inverted accumulator. The status byte is copied from `flags_i`, with the unused bits cleared.
- R9: Rotates, with the carry taking the bit that leaves the accumulator in all four cases:
  - left circular (code 9) moves bit 7 into bit 0 and into carry;
  - right circular (code 10) moves bit 0 into bit 7 and into carry;
  - left through carry (code 11) puts the old carry into bit 0;
  - right through carry (code 12) puts the old carry into bit 7.
  - All flags other than carry are copied from `flags_i`.
- R10: Complement carry (code 13) inverts `flags_i[0]`, and set carry (code 14) forces carry to 1. Both leave the accumulator and the other flags as input.
- R11: Code 15 passes `acc_i` through unchanged, and `flags_i` with its unused bits cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Capture the results on this edge |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current status byte |
| acc_o | output | 8 | Registered accumulator result |
| flags_o | output | 8 | Registered status byte |

## Verification
The bench targets four groups of corner cases:
- Results that wrap to zero, such as `0x3A + 0xC6` and `0xFF + 0x00 + 1`. A design that ignored the carry-in, or took zero from the 9-bit sum, would miss the zero flag or the carry.
- Subtract with borrow from zero, and a compare whose operand is larger. A design with an inverted borrow sense or a wrong nibble borrow would report a clear carry or half carry. A compare that wrote its difference would corrupt the accumulator.
- Rotates across both ends, and complement with all flag bits set on input. A design that lost the wrap bit, or leaked the unused flag bits, would show a wrong accumulator or set bits 5, 3 and 1.
- Thousands of random operations with random write enables, each compared against a behavioural model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMP  = 4'd7,
        OP_CMA  = 4'd8,
        OP_RLC  = 4'd9,
        OP_RRC  = 4'd10,
        OP_RAL  = 4'd11,
        OP_RAR  = 4'd12,
        OP_CMC  = 4'd13,
        OP_STC  = 4'd14,
        OP_HOLD = 4'd15
    } alu_op_e;

    // Packed from bit 7 down to bit 0; the positions are decoded by neighbours.
    typedef struct packed {
        logic sign;
        logic zero;
        logic rsv5;
        logic half;
        logic rsv3;
        logic par;
        logic rsv1;
        logic cy;
    } flag_t;

    localparam logic [7:0] FLAG_USED_MASK = 8'hD5;

    function automatic flag_t make_flags(input logic s, input logic z,
                                         input logic h, input logic p,
                                         input logic c);
        flag_t f;
        f      = '0;
        f.sign = s;
        f.zero = z;
        f.half = h;
        f.par  = p;
        f.cy   = c;
        return f;
    endfunction

    function automatic flag_t clean_flags(input logic [7:0] raw);
        return flag_t'(raw & FLAG_USED_MASK);
    endfunction

    function automatic logic is_addsub(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hcout
);
    localparam int HALF = W / 2;

    logic [W:0]    full;
    logic [HALF:0] low;

    // In subtract mode the top bit of the wrapped difference is the borrow.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
    end

    assign res   = full[W-1:0];
    assign cout  = full[W];
    assign hcout = low[HALF];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        res  = a;
        cout = cin;
        unique case (op)
            OP_AND: begin res = a & b; cout = 1'b0; end
            OP_OR:  begin res = a | b; cout = 1'b0; end
            OP_XOR: begin res = a ^ b; cout = 1'b0; end
            OP_CMA: res = ~a;
            OP_RLC: begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
            OP_RRC: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
            OP_RAL: begin res = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_RAR: begin res = {cin, a[W-1:1]};    cout = a[0];   end
            OP_CMC: cout = ~cin;
            OP_STC: cout = 1'b1;
            default: begin res = a; cout = cin; end
        endcase
    end
endmodule

// File: rtl/alu_szp.sv
module alu_szp #(
    parameter int W = 8
) (
    input  logic [W-1:0] r,
    output logic         s,
    output logic         z,
    output logic         p
);
    assign s = r[W-1];
    assign z = (r == '0);
    assign p = ~^r;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic [7:0]   flags_i,
    output logic [W-1:0] acc_o,
    output logic [7:0]   flags_o
);
    alu_op_e      op;
    flag_t        fin;
    logic [W-1:0] as_res, bit_res, nxt_acc;
    logic         as_cy, as_hc, as_sub, as_cin, bit_cy;
    logic         sz_s, sz_z, sz_p;
    logic [W-1:0] sz_src;
    flag_t        nxt_flg;
    logic [W-1:0] acc_q;
    flag_t        flg_q;

    assign op  = alu_op_e'(op_i);
    assign fin = clean_flags(flags_i);

    assign as_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBB)) ? fin.cy : 1'b0;

    alu_addsub #(.W(W)) u_addsub (
        .a(acc_i), .b(opnd_i), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_cy), .hcout(as_hc)
    );

    alu_bitops #(.W(W)) u_bitops (
        .op(op), .a(acc_i), .b(opnd_i), .cin(fin.cy),
        .res(bit_res), .cout(bit_cy)
    );

    assign sz_src = is_addsub(op) ? as_res : bit_res;

    alu_szp #(.W(W)) u_szp (.r(sz_src), .s(sz_s), .z(sz_z), .p(sz_p));

    always_comb begin
        nxt_acc = acc_i;
        nxt_flg = fin;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                nxt_acc = as_res;
                nxt_flg = make_flags(sz_s, sz_z, as_hc, sz_p, as_cy);
            end
            OP_CMP: begin
                nxt_acc = acc_i;
                nxt_flg = make_flags(sz_s, sz_z, as_hc, sz_p, as_cy);
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_acc = bit_res;
                nxt_flg = make_flags(sz_s, sz_z, 1'b0, sz_p, 1'b0);
            end
            OP_CMA: begin
                nxt_acc = bit_res;
                nxt_flg = fin;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_CMC, OP_STC: begin
                nxt_acc    = bit_res;
                nxt_flg    = fin;
                nxt_flg.cy = bit_cy;
            end
            default: begin
                nxt_acc = acc_i;
                nxt_flg = fin;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            flg_q <= '0;
        end else if (wr_en_i) begin
            acc_q <= nxt_acc;
            flg_q <= nxt_flg;
        end
    end

    assign acc_o   = acc_q;
    assign flags_o = flg_q;

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (flags_o & ~FLAG_USED_MASK) == 8'h00);

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(acc_o) && $stable(flags_o));

    assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i == 4'd7) |=> acc_o == $past(acc_i));

    assert_logic_clears_cy_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (op_i == 4'd4 || op_i == 4'd5 || op_i == 4'd6))
        |=> (flags_o[0] == 1'b0) && (flags_o[4] == 1'b0));

    assert_cma_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i == 4'd8) |=> flags_o == ($past(flags_i) & 8'hD5));

    assert_stc_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i == 4'd14) |=> flags_o[0]);

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i <= 4'd6) |=> flags_o[6] == (acc_o == '0));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc_in = 8'h00, opnd = 8'h00, flg_in = 8'h00;
    logic [7:0] acc_out, flg_out;

    int checks = 0;
    int errors = 0;
    int exp_acc = 0;
    int exp_flg = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .op_i(op),
        .acc_i(acc_in), .opnd_i(opnd), .flags_i(flg_in),
        .acc_o(acc_out), .flags_o(flg_out)
    );

    function automatic int par_even(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return ((n % 2) == 0) ? 1 : 0;
    endfunction

    function automatic int szp(input int r);
        return (((r >> 7) & 1) << 7) | ((r == 0 ? 1 : 0) << 6) | (par_even(r) << 2);
    endfunction

    function automatic string req_of(input int code);
        case (code)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5, 6: return "R7";
            7:       return "R6";
            8:       return "R8";
            9, 10, 11, 12: return "R9";
            13, 14:  return "R10";
            default: return "R11";
        endcase
    endfunction

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        int a, b, f, c, r, t;
        a = acc_in; b = opnd; f = flg_in & 8'hD5; c = f & 1;
        if (rst) begin
            exp_acc = 0; exp_flg = 0;
        end else if (wr_en) begin
            case (op)
                0, 1: begin
                    t = (op == 1) ? c : 0;
                    r = a + b + t;
                    exp_acc = r & 255;
                    exp_flg = szp(r & 255) | (((a & 15) + (b & 15) + t > 15) ? 16 : 0)
                              | (r > 255 ? 1 : 0);
                end
                2, 3, 7: begin
                    t = (op == 3) ? c : 0;
                    r = a - b - t;
                    exp_acc = (op == 7) ? a : (r & 255);
                    exp_flg = szp(r & 255) | (((a & 15) - (b & 15) - t < 0) ? 16 : 0)
                              | (r < 0 ? 1 : 0);
                end
                4: begin exp_acc = a & b; exp_flg = szp(a & b); end
                5: begin exp_acc = a | b; exp_flg = szp(a | b); end
                6: begin exp_acc = a ^ b; exp_flg = szp(a ^ b); end
                8: begin exp_acc = (~a) & 255; exp_flg = f; end
                9:  begin exp_acc = ((a << 1) | (a >> 7)) & 255; exp_flg = (f & ~1) | (a >> 7); end
                10: begin exp_acc = ((a >> 1) | (a << 7)) & 255; exp_flg = (f & ~1) | (a & 1); end
                11: begin exp_acc = ((a << 1) | c) & 255;        exp_flg = (f & ~1) | (a >> 7); end
                12: begin exp_acc = (a >> 1) | (c << 7);         exp_flg = (f & ~1) | (a & 1); end
                13: begin exp_acc = a; exp_flg = f ^ 1; end
                14: begin exp_acc = a; exp_flg = f | 1; end
                default: begin exp_acc = a; exp_flg = f; end
            endcase
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (acc_out !== exp_acc[7:0] || flg_out !== exp_flg[7:0]) begin
                errors++;
                $display("FAIL %s model op=%0d acc=%h flags=%h expected acc=%h flags=%h",
                         req_of(op), op, acc_out, flg_out, exp_acc[7:0], exp_flg[7:0]);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef);
        checks++;
        if (acc_out !== ea || flg_out !== ef) begin
            errors++;
            $display("FAIL %s acc=%h flags=%h expected acc=%h flags=%h",
                     req, acc_out, flg_out, ea, ef);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] f, input logic we);
        op = o; acc_in = a; opnd = b; flg_in = f; wr_en = we;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h00, 8'h00);
        rst = 1'b0;
        step(4'd0,  8'h3A, 8'hC6, 8'h00, 1); check("R3", 8'h00, 8'h55);
        step(4'd1,  8'hFF, 8'h00, 8'h01, 1); check("R3", 8'h00, 8'h55);
        step(4'd2,  8'h10, 8'h01, 8'h00, 1); check("R4", 8'h0F, 8'h14);
        step(4'd3,  8'h00, 8'h00, 8'h01, 1); check("R4", 8'hFF, 8'h95);
        step(4'd7,  8'h05, 8'h07, 8'h00, 1); check("R6", 8'h05, 8'h91);
        step(4'd4,  8'hF0, 8'h3C, 8'hFF, 1); check("R7", 8'h30, 8'h04);
        step(4'd6,  8'h55, 8'h55, 8'h01, 1); check("R5", 8'h00, 8'h44);
        step(4'd8,  8'h5A, 8'h00, 8'hFF, 1); check("R8", 8'hA5, 8'hD5);
        step(4'd9,  8'h81, 8'h00, 8'h00, 1); check("R9", 8'h03, 8'h01);
        step(4'd10, 8'h01, 8'h00, 8'hC4, 1); check("R9", 8'h80, 8'hC5);
        step(4'd11, 8'h80, 8'h00, 8'h01, 1); check("R9", 8'h01, 8'h01);
        step(4'd12, 8'h01, 8'h00, 8'h00, 1); check("R9", 8'h00, 8'h01);
        step(4'd13, 8'h12, 8'h00, 8'h55, 1); check("R10", 8'h12, 8'h54);
        step(4'd14, 8'h34, 8'h00, 8'h00, 1); check("R10", 8'h34, 8'h01);
        step(4'd15, 8'h77, 8'h00, 8'hFF, 1); check("R11", 8'h77, 8'hD5);
        step(4'd0,  8'h01, 8'h01, 8'h00, 0); check("R1", 8'h77, 8'hD5);
        step(4'd5,  8'hAA, 8'h2A, 8'hFF, 1); check("R2", 8'hAA, 8'h84);
        for (int i = 0; i < 4000; i++) begin
            step(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom % 4) != 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        errors++;
        checks++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule